// File: doc/BRIEF.md
# Prescaled Timer/Counter

This block is an 8-bit timer/counter that sits on a small processor's register bus. It counts ticks from one of two sources. The first source is the processor's instruction-cycle enable. The second is an external clock pin, which is synchronised and then edge-detected. An 8-bit prescaler can divide the ticks by a power of two, or it can be bypassed so that every tick advances the count.

All of the configuration lives in a 6-bit option value. This value is not mapped into the data address space: a dedicated strobe loads it, and it cannot be read back. The count itself sits at one data address and can be read and written there. A write at that address also clears the prescaler, and the ticks that fall in the next two instruction cycles are dropped. When the count wraps from its top value to zero, the block emits a one-cycle overflow pulse, which an interrupt controller elsewhere latches as a flag.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, the count is 00h and the overflow pulse is low. The option value resets to 3Fh, which selects the external pin source, falling edge and prescaler bypass.
- R2: When option bit 5 is 0 and bit 3 is 1, the count advances by one on every clock cycle in which the instruction-cycle enable is high. It holds when the enable is low.
- R3: When the count advances from FFh, it becomes 00h and the overflow output is high for exactly the next cycle. No other transition raises the overflow output, and a bus write of FFh does not raise it.
- R4: When option bit 3 is 0, the count advances once every 2^(PS+1) source ticks, where PS is option bits 2..0. The ratio therefore runs from 1:2 (PS=0) to 1:256 (PS=7).
- R5: When option bit 5 is 1, the source ticks are edges of the external pin, taken through a two-flop synchroniser. A pin change made before clock edge k is counted at edge k+2.
- R6: Option bit 4 selects the counted edge of the external pin. A value of 0 counts rising edges and a value of 1 counts falling edges. Edges of the other polarity have no effect.
- R7: A bus write at address 01h loads the count and clears the prescaler. Source ticks are then ignored until two clock cycles with the instruction-cycle enable high have passed.
- R8: The read data equals the count when the bus address is 01h, and 00h at any other address. A write at any other address leaves the count, the prescaler and the counting unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle enable |
| ext_pin | input | 1 | Asynchronous external count pin |
| opt_we | input | 1 | Load strobe for the option value |
| opt_wdata | input | 6 | Option value: [5] external source, [4] falling edge, [3] bypass, [2:0] ratio |
| bus_addr | input | ADDR_W (6) | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | CNT_W (8) | Register bus write data |
| bus_rdata | output | CNT_W (8) | Register bus read data |
| count | output | CNT_W (8) | Current count |
| ovf_pulse | output | 1 | One-cycle overflow pulse |

## Verification
The hardest state to reach is a prescaler that is part-way through a long ratio at the moment the count is written. The write must clear the hidden prescaler phase, and that only shows up as the exact cycle of the next increment. The stimulus first lets the prescaler run for a while at ratio 1:8, then writes the count and measures the gap to the next step. Random traffic then mixes option reloads, pin toggles and enable gaps, and it is compared every cycle against a model in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W   = 8;
    localparam int PRE_W   = 8;
    localparam int RATIO_W = 3;
    localparam int ADDR_W  = 6;
    localparam int OPT_W   = 3 + RATIO_W;

    typedef struct packed {
        logic               ext_src;
        logic               fall_edge;
        logic               bypass;
        logic [RATIO_W-1:0] ratio;
    } opt_t;

    localparam opt_t OPT_RESET = '{ext_src: 1'b1, fall_edge: 1'b1,
                                   bypass: 1'b1, ratio: {RATIO_W{1'b1}}};

    typedef enum logic [1:0] {
        SRC_CYCLE = 2'd0,
        SRC_RISE  = 2'd1,
        SRC_FALL  = 2'd2
    } src_sel_e;

    // Low (ratio+1) bits set: the prescaler fires when all of them are one.
    function automatic logic [PRE_W-1:0] ratio_mask(input logic [RATIO_W-1:0] r);
        logic [PRE_W:0] t;
        t = ((PRE_W+1)'(1) << (int'(r) + 1)) - (PRE_W+1)'(1);
        return t[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin};
    end

    assign rise =  sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               adv,
    input  logic               bypass,
    input  logic [RATIO_W-1:0] ratio,
    output logic               fire
);
    logic [PW-1:0] pre_q;
    logic [PW-1:0] mask;

    assign mask = PW'(ratio_mask(ratio));
    assign fire = adv & (bypass | ((pre_q & mask) == mask));

    always_ff @(posedge clk) begin
        if (rst || clr) pre_q <= '0;
        else if (adv)   pre_q <= pre_q + PW'(1);
    end
endmodule

// File: rtl/tmr_counter_core.sv
module tmr_counter_core #(
    parameter int CW       = 8,
    parameter int HOLD_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          inc,
    input  logic          cyc_en,
    output logic [CW-1:0] count,
    output logic          hold_active,
    output logic          ovf
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    logic [HW-1:0] hold_q;

    assign hold_active = (hold_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            hold_q <= '0;
            ovf    <= 1'b0;
        end else if (load) begin
            count  <= load_val;
            hold_q <= HW'(HOLD_CYC);
            ovf    <= 1'b0;
        end else begin
            if (hold_active && cyc_en) hold_q <= hold_q - HW'(1);
            if (inc) count <= count + CW'(1);
            ovf <= inc && (count == TOP);
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tmr_pkg::*;
#(
    parameter int                CW          = CNT_W,
    parameter int                PW          = PRE_W,
    parameter int                AW          = ADDR_W,
    parameter logic [ADDR_W-1:0] TMR_ADDR    = 6'h01,
    parameter int                HOLD_CYC    = 2,
    parameter int                SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_en,
    input  logic             ext_pin,
    input  logic             opt_we,
    input  logic [OPT_W-1:0] opt_wdata,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [CW-1:0]    bus_wdata,
    output logic [CW-1:0]    bus_rdata,
    output logic [CW-1:0]    count,
    output logic             ovf_pulse
);
    opt_t     opt_q;
    src_sel_e src_sel;
    logic     rise, fall, src_tick, adv, fire, hold_active, wr_hit, rd_hit;

    always_ff @(posedge clk) begin
        if (rst)         opt_q <= OPT_RESET;
        else if (opt_we) opt_q <= opt_t'(opt_wdata);
    end

    assign wr_hit = bus_we && (bus_addr == AW'(TMR_ADDR));
    assign rd_hit = (bus_addr == AW'(TMR_ADDR));

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (ext_pin),
        .rise(rise),
        .fall(fall)
    );

    always_comb begin
        if (!opt_q.ext_src)     src_sel = SRC_CYCLE;
        else if (opt_q.fall_edge) src_sel = SRC_FALL;
        else                    src_sel = SRC_RISE;
        unique case (src_sel)
            SRC_RISE: src_tick = rise;
            SRC_FALL: src_tick = fall;
            default:  src_tick = cyc_en;
        endcase
    end

    assign adv = src_tick && !hold_active && !wr_hit;

    tmr_prescaler #(.PW(PW)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (wr_hit),
        .adv   (adv),
        .bypass(opt_q.bypass),
        .ratio (opt_q.ratio),
        .fire  (fire)
    );

    tmr_counter_core #(.CW(CW), .HOLD_CYC(HOLD_CYC)) u_core (
        .clk        (clk),
        .rst        (rst),
        .load       (wr_hit),
        .load_val   (bus_wdata),
        .inc        (fire),
        .cyc_en     (cyc_en),
        .count      (count),
        .hold_active(hold_active),
        .ovf        (ovf_pulse)
    );

    assign bus_rdata = rd_hit ? count : '0;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int             CW       = 8,
    parameter int             AW       = 6,
    parameter logic [AW-1:0]  TMR_ADDR = 6'h01
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [CW-1:0] bus_wdata,
    input logic [CW-1:0] bus_rdata,
    input logic [CW-1:0] count,
    input logic          ovf_pulse
);
    logic hit;
    assign hit = bus_we && (bus_addr == TMR_ADDR) && !rst;

    // R3: a pulse only follows a wrap from the top value to zero
    p_ovf_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> (count == '0 && $past(count) == {CW{1'b1}}));

    // R3: the pulse lasts a single cycle
    p_ovf_single_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |=> !ovf_pulse);

    // R2: without a write the count either holds or steps by one
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(hit) |-> (count == $past(count) || count == $past(count) + CW'(1)));

    // R7: a write loads the count
    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        $past(hit) |-> count == $past(bus_wdata));

    // R7: the count does not move in the cycle after a load
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(hit, 2) && !$past(hit)) |-> $stable(count));

    // R8: read data tracks the count only at the timer address
    p_read_r8: assert property (@(posedge clk) disable iff (rst)
        bus_rdata == ((bus_addr == TMR_ADDR) ? count : '0));
endmodule

bind tick_timer tick_timer_chk #(.CW(CW), .AW(AW), .TMR_ADDR(AW'(TMR_ADDR))) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .count    (count),
    .ovf_pulse(ovf_pulse)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_en = 1'b1;
    logic       ext_pin = 1'b0;
    logic       opt_we = 1'b0;
    logic [5:0] opt_wdata = '0;
    logic [5:0] bus_addr = 6'h01;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, count;
    logic       ovf_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .opt_we(opt_we), .opt_wdata(opt_wdata), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .ovf_pulse(ovf_pulse)
    );

    // Reference model written from the requirements
    logic [7:0] m_cnt, m_pre;
    logic [5:0] m_opt;
    logic [1:0] m_hold;
    logic [2:0] m_sh;
    logic       m_ovf;

    function automatic logic [7:0] exp_mask(input logic [2:0] ps);
        return 8'((9'd1 << (int'(ps) + 1)) - 9'd1);
    endfunction

    always @(posedge clk) begin
        logic src, adv, inc;
        if (rst) begin
            m_cnt <= 8'h00; m_pre <= 8'h00; m_opt <= 6'h3F;
            m_hold <= 2'd0; m_sh <= 3'b000; m_ovf <= 1'b0;
        end else begin
            if (!m_opt[5])     src = cyc_en;
            else if (m_opt[4]) src = !m_sh[1] && m_sh[2];
            else               src = m_sh[1] && !m_sh[2];
            m_sh <= {m_sh[1:0], ext_pin};
            if (opt_we) m_opt <= opt_wdata;
            if (bus_we && bus_addr == 6'h01) begin
                m_cnt <= bus_wdata; m_pre <= 8'h00; m_hold <= 2'd2; m_ovf <= 1'b0;
            end else begin
                adv = src && (m_hold == 2'd0);
                inc = adv && (m_opt[3] || ((m_pre & exp_mask(m_opt[2:0])) == exp_mask(m_opt[2:0])));
                if (m_hold != 2'd0 && cyc_en) m_hold <= m_hold - 2'd1;
                if (adv) m_pre <= m_pre + 8'd1;
                if (inc) m_cnt <= m_cnt + 8'd1;
                m_ovf <= inc && (m_cnt == 8'hFF);
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        bus_addr = 6'h01; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_opt(input logic [5:0] v);
        opt_wdata = v; opt_we = 1'b1;
        @(negedge clk);
        opt_we = 1'b0;
    endtask

    task automatic report;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        logic [7:0] c;
        void'($urandom(32'h1F2E3D4C));
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        chk("R1 count", count, 8'h00);
        chk("R1 ovf", ovf_pulse, 0);
        // R1: default is external pin, falling edge, bypass
        ext_pin = 1'b1; tick(4);
        chk("R1 rising ignored", count, 8'h00);
        ext_pin = 1'b0; tick(3);
        chk("R1 falling counted", count, 8'h01);

        // R2: internal source, bypass
        wr_opt(6'h08);
        wr_cnt(8'h10); tick(12);
        chk("R2 run", count, 8'h1A);
        cyc_en = 1'b0; tick(5);
        chk("R2 enable low", count, 8'h1A);
        cyc_en = 1'b1;

        // R7: hold counts only enabled cycles
        wr_cnt(8'h40); cyc_en = 1'b0; tick(3); cyc_en = 1'b1; tick(2);
        chk("R7 hold", count, 8'h40);
        tick(1);
        chk("R7 resume", count, 8'h41);
        // R7: write clears a part-way prescaler (ratio 1:8)
        wr_opt(6'h02); tick(5);
        wr_cnt(8'h00); tick(9);
        chk("R7 prescaler cleared before", count, 8'h00);
        tick(1);
        chk("R7 prescaler cleared step", count, 8'h01);

        // R4: ratios
        wr_cnt(8'h00); tick(41);
        chk("R4 1:8 before", count, 8'h04);
        tick(1);
        chk("R4 1:8 step", count, 8'h05);
        wr_opt(6'h07); wr_cnt(8'h00); tick(257);
        chk("R4 1:256 before", count, 8'h00);
        tick(1);
        chk("R4 1:256 step", count, 8'h01);
        wr_opt(6'h00); wr_cnt(8'h00); tick(3);
        chk("R4 1:2 before", count, 8'h00);
        tick(1);
        chk("R4 1:2 step", count, 8'h01);

        // R3: overflow
        wr_opt(6'h08); wr_cnt(8'hFF); tick(1);
        chk("R3 no pulse on write", ovf_pulse, 0);
        wr_cnt(8'hFE); tick(3);
        chk("R3 at top", count, 8'hFF);
        chk("R3 no early pulse", ovf_pulse, 0);
        tick(1);
        chk("R3 wrap", count, 8'h00);
        chk("R3 pulse", ovf_pulse, 1);
        tick(1);
        chk("R3 pulse ends", ovf_pulse, 0);

        // R5 / R6: external pin, rising
        wr_opt(6'h28); wr_cnt(8'h00); tick(3);
        ext_pin = 1'b1; tick(2);
        chk("R5 latency", count, 8'h00);
        tick(1);
        chk("R5 rising counted", count, 8'h01);
        ext_pin = 1'b0; tick(5);
        chk("R6 falling ignored", count, 8'h01);
        wr_opt(6'h38);
        ext_pin = 1'b1; tick(5);
        chk("R6 rising ignored", count, 8'h01);
        ext_pin = 1'b0; tick(3);
        chk("R6 falling counted", count, 8'h02);

        // R8: read mux and foreign writes
        wr_opt(6'h08); cyc_en = 1'b0; tick(1);
        c = count;
        bus_addr = 6'h05; #1;
        chk("R8 other address reads zero", bus_rdata, 8'h00);
        bus_addr = 6'h01; #1;
        chk("R8 timer address reads count", bus_rdata, c);
        bus_addr = 6'h02; bus_wdata = 8'h99; bus_we = 1'b1; tick(1); bus_we = 1'b0;
        chk("R8 foreign write ignored", count, c);
        cyc_en = 1'b1; tick(1);
        chk("R8 no hold after foreign write", count, 8'(c + 8'd1));

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            cyc_en  = ($urandom % 4) != 0;
            if (($urandom % 3) == 0) ext_pin = ~ext_pin;
            bus_addr = 6'($urandom % 4);
            bus_we   = ($urandom % 16) == 0;
            bus_wdata = 8'($urandom);
            if (($urandom % 8) == 0) bus_wdata = 8'hFD;
            opt_we   = ($urandom % 40) == 0;
            opt_wdata = 6'($urandom);
            tick(1);
            chk("R4 random count", count, m_cnt);
            chk("R3 random ovf", ovf_pulse, m_ovf);
            chk("R8 random rdata", bus_rdata, (bus_addr == 6'h01) ? m_cnt : 8'h00);
        end
        done = 1'b1;
        report();
    end
endmodule